// File: doc/BRIEF.md
# Critical-Word-First Wrap Read Sequencer

This block sits between a cache miss handler and an AXI3-style read address and data channel. A miss request carries the byte address that missed. The block rounds that address down to a whole beat and issues one read request with WRAP burst type. The request length and size are fixed by parameters that give the beat width and the number of beats in a cache line. Because the request starts at the beat that holds the requested word, that word arrives first and the rest of the line follows.

Once the request has been accepted, the block tracks the data beats as they are handed over. For every beat it presents that beat's byte address, which climbs by one beat width and folds back inside the line-sized window. It marks the critical first beat and pulses a flag on the beat where the address returns to the line start. On the final beat it pulses done and goes idle. It always uses a WRAP burst, even when the miss falls on the first word of the line. In that case the sequence simply never folds back.

Top module: `cwf_wrap_seq`

## Requirements
- R1: The issued request address equals the miss address with its low log2(beat bytes) bits cleared.
- R2: Every request carries burst type 2'b10 (WRAP), length field equal to beat count minus one, and size field equal to log2 of the beat width in bytes. This holds even when the miss hits the first beat of the line.
- R3: While the request valid is high and the request ready is low, the request valid stays high and the request address does not change.
- R4: The first beat address equals the issued request address. The critical-beat flag is high on the first beat and low on every later beat.
- R5: Each following beat address is lineBase + ((previous − lineBase + beat bytes) mod window). Here window is beat bytes × beat count and lineBase is the miss address with its low log2(window) bits cleared.
- R6: The beat address moves only on a cycle in which both beat valid and beat ready are high. It stays unchanged through stalled cycles.
- R7: The wrapped flag is high for exactly the handshake beat, other than the first beat, whose address equals lineBase. It never goes high when the burst starts at lineBase.
- R8: Done is high on the handshake of the beat-count-th beat and on no other cycle. The block is idle in the following cycle.
- R9: Busy is high from the accepted miss until the cycle after done, and miss ready is its inverse. A miss presented while busy is not accepted and leaves the pending request address unchanged.
- R10: After reset, busy is low, miss ready is high, request valid is low and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss request present |
| missAddr | input | ADDR_W | Byte address that missed |
| missReady | output | 1 | Miss request can be accepted |
| busy | output | 1 | A burst is outstanding |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request accepted downstream |
| arAddr | output | ADDR_W | Beat-aligned burst start address |
| arLen | output | 4 | Beats minus one |
| arSize | output | 3 | log2 of beat bytes |
| arBurst | output | 2 | Burst type, 2'b10 for WRAP |
| rValid | input | 1 | Data beat valid |
| rReady | input | 1 | Data beat taken by consumer |
| beatAddr | output | ADDR_W | Byte address of the current beat |
| critBeat | output | 1 | Current beat is the critical first beat |
| wrapped | output | 1 | This handshake beat folded back to the line start |
| done | output | 1 | This handshake beat is the last of the burst |

## Verification
Directed misses cover four cases. A miss at the line start shows that the burst stays WRAP and never raises the wrapped flag. A miss on the last word wraps on the second beat. A mid-line miss wraps partway through. An unaligned byte address checks the round-down. Random addresses, random request-accept delays and random beat stalls then cover every start offset. Each delay and stall checks that the request and beat address hold still until their handshake. While the block is busy, misses with different addresses are also presented, which shows that they change neither the pending request nor the beat sequence.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/cwf_datapath.sv
module cwf_datapath
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  parameter int BEAT_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] missAddr,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              firstBeat,
  output logic              lastBeat,
  output logic              atLower
);
  localparam int WIN_BYTES = BEAT_BYTES * BEAT_COUNT;
  localparam int IDX_W     = (BEAT_COUNT > 1) ? $clog2(BEAT_COUNT) : 1;
  localparam logic [ADDR_W-1:0] BEAT_MASK = ADDR_W'(BEAT_BYTES - 1);
  localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'(WIN_BYTES - 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] lowerBound;
  logic [ADDR_W-1:0] nextAddr;
  logic [IDX_W-1:0]  beatIdx;

  always_comb begin
    nextAddr = lowerBound | ((curAddr + STEP) & WIN_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startAddr  <= '0;
      curAddr    <= '0;
      lowerBound <= '0;
      beatIdx    <= '0;
    end else if (strobe.load) begin
      startAddr  <= missAddr & ~BEAT_MASK;
      curAddr    <= missAddr & ~BEAT_MASK;
      lowerBound <= missAddr & ~WIN_MASK;
      beatIdx    <= '0;
    end else if (strobe.advance) begin
      curAddr <= nextAddr;
      beatIdx <= beatIdx + 1'b1;
    end
  end

  assign firstBeat = (beatIdx == '0);
  assign lastBeat  = (beatIdx == IDX_W'(BEAT_COUNT - 1));
  assign atLower   = (curAddr == lowerBound);

  // R5: the beat address never leaves the line window
  assert_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (curAddr & ~WIN_MASK) == (startAddr & ~WIN_MASK));
endmodule

// File: rtl/cwf_control.sv
module cwf_control
  import cwf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       missValid,
  input  logic       arReady,
  input  logic       rValid,
  input  logic       rReady,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic       reqPhase,
  output logic       dataPhase,
  output logic       idle
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_IDLE: if (missValid) begin
        strobe.load = 1'b1;
        stateNext   = ST_REQ;
      end
      ST_REQ: if (arReady) stateNext = ST_DATA;
      ST_DATA: if (rValid && rReady) begin
        strobe.advance = 1'b1;
        if (lastBeat) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign idle      = (state == ST_IDLE);
  assign reqPhase  = (state == ST_REQ);
  assign dataPhase = (state == ST_DATA);

  // R3: the request is held until accepted
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqPhase && !arReady) |=> reqPhase);
endmodule

// File: rtl/cwf_wrap_seq.sv
module cwf_wrap_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  parameter int BEAT_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              missReady,
  output logic              busy,
  output logic              arValid,
  input  logic              arReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [3:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  input  logic              rValid,
  input  logic              rReady,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              critBeat,
  output logic              wrapped,
  output logic              done
);
  localparam int SIZE_LOG = $clog2(BEAT_BYTES);
  localparam logic [1:0] BURST_WRAP = 2'b10;

  generate
    if (!(BEAT_COUNT == 2 || BEAT_COUNT == 4 || BEAT_COUNT == 8 || BEAT_COUNT == 16)) begin : g_bad_count
      $error("BEAT_COUNT must be 2, 4, 8 or 16");
    end
    if ((1 << SIZE_LOG) != BEAT_BYTES || SIZE_LOG > 7) begin : g_bad_width
      $error("BEAT_BYTES must be a power of two up to 128");
    end
  endgenerate

  seqStrobe_t strobe;
  logic reqPhase, dataPhase, idle;
  logic firstBeat, lastBeat, atLower;
  logic [ADDR_W-1:0] startAddr, curAddr;
  logic beatFire;

  cwf_control u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .missValid (missValid),
    .arReady   (arReady),
    .rValid    (rValid),
    .rReady    (rReady),
    .lastBeat  (lastBeat),
    .strobe    (strobe),
    .reqPhase  (reqPhase),
    .dataPhase (dataPhase),
    .idle      (idle)
  );

  cwf_datapath #(
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .BEAT_COUNT (BEAT_COUNT)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .missAddr  (missAddr),
    .startAddr (startAddr),
    .curAddr   (curAddr),
    .firstBeat (firstBeat),
    .lastBeat  (lastBeat),
    .atLower   (atLower)
  );

  assign beatFire  = dataPhase && rValid && rReady;
  assign missReady = idle;
  assign busy      = !idle;
  assign arValid   = reqPhase;
  assign arAddr    = startAddr;
  assign arLen     = 4'(BEAT_COUNT - 1);
  assign arSize    = 3'(SIZE_LOG);
  assign arBurst   = BURST_WRAP;
  assign beatAddr  = curAddr;
  assign critBeat  = dataPhase && firstBeat;
  assign wrapped   = beatFire && !firstBeat && atLower;
  assign done      = beatFire && lastBeat;

  // R3: request address is frozen while waiting for acceptance
  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arValid && !arReady) |=> (arValid && $stable(arAddr)));
  // R4: first beat starts at the issued request address
  assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataPhase) |-> (beatAddr == arAddr && critBeat));
  // R6: a stalled beat keeps its address
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dataPhase && !(rValid && rReady)) |=> $stable(beatAddr));
  // R7: the wrap flag never marks the critical beat
  assert_wrap_not_crit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |-> !critBeat);
  // R8: the block is idle right after done
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && missReady));
  // R9: a burst in flight ignores new misses
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(arAddr)));
endmodule

// File: tb/cwf_wrap_seq_bench.sv
module cwf_wrap_seq_bench;
  localparam int ADDR_W = 32;
  localparam int BB     = 4;
  localparam int BC     = 4;
  localparam int WIN    = BB * BC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic missValid = 1'b0;
  logic [ADDR_W-1:0] missAddr = '0;
  logic missReady, busy, arValid, arReady;
  logic [ADDR_W-1:0] arAddr, beatAddr;
  logic [3:0] arLen;
  logic [2:0] arSize;
  logic [1:0] arBurst;
  logic rValid, rReady, critBeat, wrapped, done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cwf_wrap_seq #(.ADDR_W(ADDR_W), .BEAT_BYTES(BB), .BEAT_COUNT(BC)) u_cwf_wrap_seq (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .missAddr(missAddr),
    .missReady(missReady), .busy(busy), .arValid(arValid), .arReady(arReady),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .rValid(rValid), .rReady(rReady), .beatAddr(beatAddr), .critBeat(critBeat),
    .wrapped(wrapped), .done(done)
  );

  function automatic logic [ADDR_W-1:0] expStart(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(BB - 1);
  endfunction
  function automatic logic [ADDR_W-1:0] expLower(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(WIN - 1);
  endfunction
  function automatic logic [ADDR_W-1:0] expBeat(input logic [ADDR_W-1:0] a, input int i);
    logic [ADDR_W-1:0] lo;
    lo = expLower(a);
    return lo + ((expStart(a) - lo + ADDR_W'(i * BB)) % ADDR_W'(WIN));
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runBurst(input logic [ADDR_W-1:0] a, input int arDelay, input int stallPct, input bit pokeMiss);
    logic [ADDR_W-1:0] e;
    @(negedge clk);
    missValid = 1'b1; missAddr = a;
    #1 check("R9 missReady idle", missReady, 1);
    @(posedge clk); #0;
    for (int d = 0; d <= arDelay; d++) begin
      @(negedge clk);
      missValid = pokeMiss; missAddr = a ^ 32'h0000_0040;
      arReady = (d == arDelay);
      #1;
      check("R3 arValid held", arValid, 1);
      check("R1 arAddr aligned", arAddr, expStart(a));
      check("R2 arBurst WRAP", arBurst, 2'b10);
      check("R2 arLen", arLen, BC - 1);
      check("R2 arSize", arSize, 2);
      check("R9 busy", busy, 1);
      check("R9 missReady low", missReady, 0);
    end
    @(posedge clk);
    for (int i = 0; i < BC; i++) begin
      e = expBeat(a, i);
      forever begin
        @(negedge clk);
        arReady = 1'b0;
        missValid = pokeMiss; missAddr = a + 32'h100;
        if (($urandom % 100) < stallPct) begin
          rValid = $urandom % 2; rReady = !rValid;
          #1;
          check("R6 stall beatAddr", beatAddr, e);
          check("R8 no done on stall", done, 0);
          check("R7 no wrap on stall", wrapped, 0);
        end else begin
          rValid = 1'b1; rReady = 1'b1;
          #1;
          check(i == 0 ? "R4 first beat addr" : "R5 beat addr", beatAddr, e);
          check("R4 critBeat", critBeat, i == 0);
          check("R7 wrapped", wrapped, (i > 0) && (e == expLower(a)));
          check("R8 done", done, i == BC - 1);
          break;
        end
      end
    end
    @(negedge clk);
    rValid = 1'b0; rReady = 1'b0; missValid = 1'b0;
    #1;
    check("R8 idle after done", busy, 0);
    check("R9 missReady after done", missReady, 1);
    check("R8 done single", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    arReady = 1'b0; rValid = 1'b0; rReady = 1'b0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R10 busy reset", busy, 0);
    check("R10 missReady reset", missReady, 1);
    check("R10 arValid reset", arValid, 0);
    check("R10 done reset", done, 0);
    rst_n = 1'b1;
    runBurst(32'h0000_1000, 0, 0, 0);   // line start: never wraps, still WRAP
    runBurst(32'h0000_100C, 2, 0, 1);   // last word: wraps on second beat
    runBurst(32'h0000_1008, 1, 30, 1);  // mid line
    runBurst(32'h0000_100B, 3, 50, 0);  // unaligned byte rounds down
    for (int n = 0; n < 40; n++) begin
      runBurst($urandom, $urandom % 4, $urandom % 60, $urandom % 2);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule